// File: doc/BRIEF.md
# Temperature Threshold Alert Qualifier

This block watches a stream of 16-bit signed temperature samples. It compares each one with a high and a low limit, and drives an alert line and an alert status bit. A small streak counter requires a set number of qualifying samples in a row before the alert changes state. This filters out single noisy readings.

Two behaviours are available:

- **Comparator mode** gives hysteresis. The alert turns on after a run of high readings and turns off after a run of low readings.
- **Interrupt mode** gives a latched event. A run on the armed side raises the alert, and the alert stays raised until software reads a register or the sensor is put to sleep. The armed side then flips, so high and low events alternate.

The surrounding logic owns the registers and the bus. It feeds in the limits, the mode fields, a sample strobe, a register-read strobe and a sleep-entry strobe.

Top module: `temp_alert_cmp`

## Requirements
- R1: The streak length N is `cfg_faults`+1: code 0 needs 1 sample, code 1 needs 2, code 2 needs 3 and code 3 needs 4 consecutive qualifying samples.
- R2: A high fault is sample ≥ high limit and a low fault is sample ≤ low limit. Both compares are signed two's complement. Bits 3:0 of both limits are treated as zero, whatever their input value.
- R3: In comparator mode (`cfg_latch`=0), the alert turns active after N consecutive high faults. It turns inactive after N consecutive low faults.
- R4: A sample that does not qualify for the side currently watched restarts the streak from zero.
- R5: In interrupt mode (`cfg_latch`=1), the first activation needs N high faults. A read strobe or a sleep strobe clears the alert. After each clear the armed side flips, so the next activation needs N low faults, then N high faults, and so on.
- R6: While the interrupt-mode alert is active, samples have no effect. Read and sleep strobes have no effect while the alert is inactive, and they have no effect at all in comparator mode.
- R7: With `cfg_pol`=0 the `alert_o` pin is active low. With `cfg_pol`=1 it is active high.
- R8: The status bit `alert_flag_o` follows the most recent completed crossing: the side (high or low) of the last streak that changed the alert. It reads as the inactive level (1 when `cfg_pol`=0) after a low crossing or a reset, and as the active level after a high crossing. In comparator mode it therefore equals `alert_o`. In interrupt mode it does not change when a read or sleep clears the alert.
- R9: Any change of `cfg_latch` takes effect at the next clock edge. It returns the alert and status to inactive, arms the high side and clears the streak. Any sample or strobe presented in that same cycle is discarded.
- R10: Outputs change at the clock edge that samples the strobe. After reset the alert and status are inactive and the high side is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_vld | input | 1 | New temperature sample present |
| smp_data | input | 16 | Temperature sample, two's complement |
| lim_hi | input | 16 | High limit |
| lim_lo | input | 16 | Low limit |
| cfg_faults | input | 2 | Streak length code (N = code+1) |
| cfg_latch | input | 1 | 0 comparator mode, 1 interrupt mode |
| cfg_pol | input | 1 | Alert pin polarity, 1 = active high |
| rd_stb | input | 1 | A register read took place |
| sleep_stb | input | 1 | Sleep mode was entered |
| alert_o | output | 1 | Alert pin level |
| alert_flag_o | output | 1 | Alert status bit level |

## Verification
Every state change is registered once, so each stimulus result is due one edge after it is presented. Polarity acts on the outputs combinationally.

The bench drives each stimulus shortly after a falling edge. It queues the expected pin and status levels just after the following rising edge, and a monitor compares them at the next falling edge. A change of polarity therefore always lands after the comparison of the previous item.

Streak runs that are broken, equality at both limits, masked limit nibbles, negative values and mode switches mid-streak are all placed on that same one-edge schedule.

// File: rtl/temp_alert_cmp.sv
module temp_alert_cmp #(
  parameter int W     = 16,
  parameter int ZBITS = 4,
  parameter int CW    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_vld,
  input  logic [W-1:0]  smp_data,
  input  logic [W-1:0]  lim_hi,
  input  logic [W-1:0]  lim_lo,
  input  logic [CW-1:0] cfg_faults,
  input  logic          cfg_latch,
  input  logic          cfg_pol,
  input  logic          rd_stb,
  input  logic          sleep_stb,
  output logic          alert_o,
  output logic          alert_flag_o
);
  localparam logic [W-1:0] LIM_MASK = {{(W-ZBITS){1'b1}}, {ZBITS{1'b0}}};

  logic          active, hot, arm_low, latch_q;
  logic [CW-1:0] cnt;

  logic hi_f, lo_f, side_low, qual, hit, clr, mode_chg, take;

  assign hi_f     = $signed(smp_data) >= $signed(lim_hi & LIM_MASK);
  assign lo_f     = $signed(smp_data) <= $signed(lim_lo & LIM_MASK);
  assign side_low = cfg_latch ? arm_low : active;
  assign qual     = side_low ? lo_f : hi_f;
  assign hit      = qual && (cnt == cfg_faults);
  assign clr      = cfg_latch && active && (rd_stb || sleep_stb);
  assign mode_chg = cfg_latch != latch_q;
  assign take     = smp_vld && !(cfg_latch && active);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      hot     <= 1'b0;
      arm_low <= 1'b0;
      cnt     <= '0;
      latch_q <= 1'b0;
    end else begin
      latch_q <= cfg_latch;
      if (mode_chg) begin
        active  <= 1'b0;
        hot     <= 1'b0;
        arm_low <= 1'b0;
        cnt     <= '0;
      end else if (clr) begin
        active  <= 1'b0;
        arm_low <= ~arm_low;
        cnt     <= '0;
      end else if (take) begin
        if (hit) begin
          cnt <= '0;
          if (cfg_latch) begin
            active <= 1'b1;
            hot    <= ~arm_low;
          end else begin
            active <= ~active;
            hot    <= ~active;
          end
        end else if (qual) begin
          cnt <= cnt + 1'b1;
        end else begin
          cnt <= '0;
        end
      end
    end
  end

  assign alert_o      = cfg_pol ? active : ~active;
  assign alert_flag_o = cfg_pol ? hot : ~hot;
endmodule

// File: rtl/temp_alert_cmp_chk.sv
module temp_alert_cmp_chk #(
  parameter int CW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          smp_vld,
  input logic          cfg_latch,
  input logic          latch_q,
  input logic          rd_stb,
  input logic          sleep_stb,
  input logic          active,
  input logic [CW-1:0] cnt,
  input logic          alert_o,
  input logic          alert_flag_o
);
  // R8
  flag_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_latch && !latch_q) |-> (alert_flag_o == alert_o));

  // R5
  int_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_latch && active && (rd_stb || sleep_stb)) |=> !active);

  // R9
  mode_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_latch != latch_q) |=> (!active && cnt == '0));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_vld && !rd_stb && !sleep_stb && cfg_latch == latch_q) |=> $stable(active));

  // R6
  latched_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_latch && latch_q && active && !rd_stb && !sleep_stb) |=> active);
endmodule

bind temp_alert_cmp temp_alert_cmp_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .cfg_latch(cfg_latch),
  .latch_q(latch_q), .rd_stb(rd_stb), .sleep_stb(sleep_stb),
  .active(active), .cnt(cnt), .alert_o(alert_o), .alert_flag_o(alert_flag_o)
);

// File: tb/test_temp_alert_cmp.sv
module test_temp_alert_cmp;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_vld = 1'b0, rd_stb = 1'b0, sleep_stb = 1'b0;
  logic [15:0] smp_data = '0;
  logic [15:0] lim_hi = 16'h2800, lim_lo = 16'h2580;
  logic [1:0]  cfg_faults = 2'd0;
  logic cfg_latch = 1'b0, cfg_pol = 1'b0;
  logic alert_o, alert_flag_o;

  logic [15:0] n_hi = 16'h2800, n_lo = 16'h2580;
  logic [1:0]  n_cf = 2'd0;
  logic n_im = 1'b0, n_pol = 1'b0;

  int m_act = 0, m_hot = 0, m_arm = 0, m_cnt = 0, m_imq = 0;
  logic [1:0] q_exp[$];
  string      q_tag[$];
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  temp_alert_cmp i_temp_alert_cmp (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_data(smp_data),
    .lim_hi(lim_hi), .lim_lo(lim_lo), .cfg_faults(cfg_faults),
    .cfg_latch(cfg_latch), .cfg_pol(cfg_pol), .rd_stb(rd_stb),
    .sleep_stb(sleep_stb), .alert_o(alert_o), .alert_flag_o(alert_flag_o)
  );

  task automatic step(input bit v, input logic [15:0] d, input bit r,
                      input bit s, input string tag);
    bit hf, lf, q, side;
    @(negedge clk); #2;
    smp_vld = v; smp_data = d; rd_stb = r; sleep_stb = s;
    lim_hi = n_hi; lim_lo = n_lo; cfg_faults = n_cf; cfg_latch = n_im; cfg_pol = n_pol;
    hf = $signed(d) >= $signed(n_hi & 16'hFFF0);
    lf = $signed(d) <= $signed(n_lo & 16'hFFF0);
    if (int'(n_im) != m_imq) begin
      m_act = 0; m_hot = 0; m_arm = 0; m_cnt = 0;
    end else if (n_im && m_act == 1 && (r || s)) begin
      m_act = 0; m_arm = 1 - m_arm; m_cnt = 0;
    end else if (v && !(n_im && m_act == 1)) begin
      side = n_im ? (m_arm == 1) : (m_act == 1);
      q = side ? lf : hf;
      if (!q) m_cnt = 0;
      else if (m_cnt + 1 == int'(n_cf) + 1) begin
        m_cnt = 0;
        if (n_im) begin m_act = 1; m_hot = 1 - m_arm; end
        else begin m_hot = 1 - m_act; m_act = 1 - m_act; end
      end else m_cnt++;
    end
    m_imq = int'(n_im);
    @(posedge clk); #1;
    q_exp.push_back({n_pol ? m_act[0] : ~m_act[0], n_pol ? m_hot[0] : ~m_hot[0]});
    q_tag.push_back(tag);
  endtask

  always @(negedge clk) begin
    if (q_exp.size() > 0) begin
      logic [1:0] e;
      string t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      checks++;
      if ({alert_o, alert_flag_o} !== e) begin
        fails++;
        $display("FAIL %s: pin/flag actual %b%b expected %b%b", t, alert_o, alert_flag_o, e[1], e[0]);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    step(0, 16'h0, 0, 0, "R10 reset");
    step(1, 16'h2800, 0, 0, "R3 R2 high equal");
    step(1, 16'h2600, 0, 0, "R3 between");
    step(1, 16'h2580, 0, 0, "R3 R2 low equal");
    n_cf = 2'd1;
    step(1, 16'h3000, 0, 0, "R1 first of two");
    step(1, 16'h3000, 0, 0, "R1 second of two");
    step(1, 16'h2000, 0, 0, "R4 low one");
    step(1, 16'h2700, 0, 0, "R4 break");
    step(1, 16'h2000, 0, 0, "R4 restart");
    step(1, 16'h2000, 0, 0, "R4 low done");
    n_cf = 2'd0;
    step(1, 16'h3000, 0, 0, "R3 set");
    step(0, 16'h0, 1, 0, "R6 read comparator");
    step(0, 16'h0, 0, 1, "R6 sleep comparator");
    step(1, 16'h0000, 0, 0, "R3 clear");
    n_hi = 16'h280F; n_lo = 16'h258F;
    step(1, 16'h2805, 0, 0, "R2 mask high");
    step(1, 16'h2588, 0, 0, "R2 mask low");
    step(1, 16'h2580, 0, 0, "R2 low clear");
    n_hi = 16'hEC00; n_lo = 16'hE000;
    step(1, 16'h8000, 0, 0, "R2 most negative");
    step(1, 16'h0100, 0, 0, "R2 signed high");
    step(1, 16'hD000, 0, 0, "R2 signed low");
    n_hi = 16'h2800; n_lo = 16'h2580; n_cf = 2'd3;
    for (int i = 0; i < 4; i++) step(1, 16'h3000, 0, 0, "R1 four");
    n_pol = 1'b1;
    step(0, 16'h0, 0, 0, "R7 active high");
    for (int i = 0; i < 4; i++) step(1, 16'h1000, 0, 0, "R7 R1 low four");
    n_pol = 1'b0; n_cf = 2'd0; n_im = 1'b1;
    step(1, 16'h3000, 0, 0, "R9 mode switch");
    step(1, 16'h3000, 0, 0, "R5 high event");
    step(1, 16'h0000, 0, 0, "R6 ignored active");
    step(0, 16'h0, 1, 0, "R5 R8 read clear");
    step(1, 16'h3000, 0, 0, "R5 armed low");
    step(1, 16'h2000, 0, 0, "R5 R8 low event");
    step(0, 16'h0, 0, 1, "R5 sleep clear");
    step(0, 16'h0, 1, 0, "R6 read inactive");
    step(1, 16'h2000, 0, 0, "R5 armed high");
    step(1, 16'h3000, 0, 0, "R5 high again");
    n_im = 1'b0;
    step(1, 16'h3000, 0, 0, "R9 to comparator");
    step(1, 16'h2000, 0, 0, "R9 high armed");
    step(1, 16'h3000, 0, 0, "R9 R8 set");
    n_cf = 2'd1; n_im = 1'b1;
    step(1, 16'h3000, 0, 0, "R9 discard");
    step(1, 16'h3000, 0, 0, "R9 R1 one");
    step(1, 16'h3000, 0, 0, "R9 R1 two");
    step(0, 16'h0, 0, 0, "R10 idle");
    @(negedge clk); @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule